// File: doc/BRIEF.md
# Watchdog Timer with NMI Grace Window

This block is a software watchdog. Software keeps it alive by writing a reload value into a 16-bit register. An internal prescaler divides the clock into a slow tick, and the count drops by one on each tick. The count is a 9-bit two's-complement value, so after zero it carries on into negative numbers.

A mode input picks what happens when the count runs out. In the warning mode (mode 0), a non-maskable interrupt fires when the count reaches zero. The count then keeps falling through a grace window, and a system reset fires when the count reaches 0x1F0. In the strict mode (mode 1), the system reset fires as soon as a tick leaves the count at zero or below, and no interrupt is raised. After each system reset the count starts again from 0xFF.

Writes pass through a filter: a write whose upper seven data bits are not all zero is dropped. This protects the watchdog against stray stores from software that has run away. The read port always shows the live count together with its sign bit.

Top module: `wdog_grace_timer`

## Requirements
- R1: After reset the count reads 0x0FF and both nmi_o and sys_rst_o are low.
- R2: A write with wr_data_i[15:9] all zero loads wr_data_i[7:0] into the count and clears the sign bit (bit 8 of the count). Bit 8 of the written data is ignored.
- R3: A write with any bit of wr_data_i[15:9] set leaves the count unchanged.
- R4: The count drops by one on each tick. A tick occurs every TICK_CYCLES clocks. An accepted write restarts the prescaler, so the first decrement lands TICK_CYCLES clock edges after the edge that loaded the count.
- R5: The count is 9 bits wide and wraps from 0 to 0x1FF, 0x1FE and so on. rd_data_o returns the count in bits 8:0, with bit 8 as the sign, and zeros in bits 15:9.
- R6: In mode 0, nmi_o is high for exactly one clock: the clock in which a tick has just brought the count to 0.
- R7: In mode 0, the tick that would bring the count to 0x1F0 instead makes sys_rst_o high for one clock and reloads the count with 0x0FF.
- R8: In mode 1, a tick whose result is zero or negative makes sys_rst_o high for one clock and reloads 0x0FF. nmi_o stays low in this mode.
- R9: When an accepted write and a tick fall in the same cycle, the write value is loaded and the decrement is skipped.
- R10: After a system reset pulse, the count keeps falling from 0x0FF on the following ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: NMI at zero, then reset at the end of the grace window; 1: reset as soon as the count is zero or negative |
| wr_en_i | input | 1 | Write strobe for the reload register |
| wr_data_i | input | 16 | Write data; bits 7:0 are the reload value, bits 15:9 must be zero |
| rd_data_o | output | 16 | Live count: bits 8:0, sign in bit 8, upper bits zero |
| nmi_o | output | 1 | One-clock non-maskable interrupt pulse |
| sys_rst_o | output | 1 | One-clock system reset request pulse |

## Verification
The assertions assume that mode_i and wr_en_i are synchronous to clk and settle before each rising edge. They also assume that software never writes a negative value, since only the low eight bits can be loaded. The bench changes every input on the falling edge and reads on the falling edge, so each rising edge sees stable values. It uses a short prescaler period, so the grace window and both reload paths are reached within a few hundred cycles. It sets the mode only together with a reload, so the count always starts from a non-negative value.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int WDG_REG_W    = 16;
  localparam int WDG_LOAD_W   = 8;
  localparam int WDG_CNT_W    = WDG_LOAD_W + 1;
  localparam int WDG_GUARD_LO = WDG_CNT_W;
  localparam logic [WDG_CNT_W-1:0] WDG_RELOAD    = 9'h0FF;
  localparam logic [WDG_CNT_W-1:0] WDG_NMI_AT    = 9'h000;
  localparam logic [WDG_CNT_W-1:0] WDG_GRACE_END = 9'h1F0;

  typedef logic [WDG_CNT_W-1:0] wdg_cnt_t;

  // a reload passes the filter only with its guard bits clear
  function automatic logic wdg_accept(input logic [WDG_REG_W-1:0] d);
    return d[WDG_REG_W-1:WDG_GUARD_LO] == '0;
  endfunction

  function automatic wdg_cnt_t wdg_dec(input wdg_cnt_t c);
    return c - wdg_cnt_t'(1);
  endfunction

  // zero or sign bit set
  function automatic logic wdg_nonpos(input wdg_cnt_t c);
    return (c == '0) || c[WDG_CNT_W-1];
  endfunction

  function automatic wdg_cnt_t wdg_load(input logic [WDG_REG_W-1:0] d);
    return {1'b0, d[WDG_LOAD_W-1:0]};
  endfunction
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int TICK_CYCLES = 2048000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  generate
    if (TICK_CYCLES > 1) begin : g_div
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         pcnt <= '0;
        else if (restart_i || pcnt == LAST) pcnt <= '0;
        else                                pcnt <= pcnt + PW'(1);
      end
      assign tick_o = (pcnt == LAST);

      // R4: a tick never lasts two cycles
      p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
      // R4: a restart is followed by a quiet cycle
      p_restart_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o);
    end else begin : g_every
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/wdg_decide.sv
module wdg_decide
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mode_i,
  input  logic     tick_i,
  input  logic     accept_i,
  input  wdg_cnt_t cnt_i,
  output wdg_cnt_t next_o,
  output logic     step_o,
  output logic     nmi_hit_o,
  output logic     rst_hit_o,
  output logic     nmi_o,
  output logic     sys_rst_o
);
  // an accepted write owns the cycle, so a tick is dropped (R9)
  assign step_o = tick_i && !accept_i;
  assign next_o = wdg_dec(cnt_i);

  always_comb begin
    nmi_hit_o = 1'b0;
    rst_hit_o = 1'b0;
    if (step_o) begin
      if (mode_i) begin
        rst_hit_o = wdg_nonpos(next_o);
      end else begin
        nmi_hit_o = (next_o == WDG_NMI_AT);
        rst_hit_o = (next_o == WDG_GRACE_END);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_o     <= 1'b0;
      sys_rst_o <= 1'b0;
    end else begin
      nmi_o     <= nmi_hit_o;
      sys_rst_o <= rst_hit_o;
    end
  end

  // R6: one-clock interrupt
  p_nmi_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |=> !nmi_o);
  // R8: strict mode never asks for an interrupt
  p_no_nmi_strict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i |=> !nmi_o);
  // R7/R8: reset request is a single clock
  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);
endmodule

// File: rtl/wdg_count.sv
module wdg_count
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  wdg_cnt_t load_val_i,
  input  logic     step_i,
  input  logic     reload_i,
  input  wdg_cnt_t next_i,
  output wdg_cnt_t cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_o <= WDG_RELOAD;
    else if (load_i)   cnt_o <= load_val_i;
    else if (reload_i) cnt_o <= WDG_RELOAD;
    else if (step_i)   cnt_o <= next_i;
  end

  // R2: an accepted write lands next cycle with the sign clear
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_o == $past(load_val_i)) && !cnt_o[WDG_CNT_W-1]);
  // R3: nothing changes without a load or a tick
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(cnt_o));
  // R5: plain step is a 9-bit decrement
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !reload_i) |=> cnt_o == $past(cnt_o) - 9'd1);
  // R10: a reset request restarts from the reload value
  p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && !load_i) |=> cnt_o == WDG_RELOAD);
endmodule

// File: rtl/wdog_grace_timer.sv
module wdog_grace_timer
  import wdg_pkg::*;
#(
  parameter int TICK_CYCLES = 2048000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  output logic        nmi_o,
  output logic        sys_rst_o
);
  logic     accept;
  logic     tick;
  logic     step;
  logic     nmi_hit;
  logic     rst_hit;
  wdg_cnt_t cnt;
  wdg_cnt_t next_cnt;
  wdg_cnt_t load_val;

  assign accept   = wr_en_i && wdg_accept(wr_data_i);
  assign load_val = wdg_load(wr_data_i);

  wdg_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (accept),
    .tick_o    (tick)
  );

  wdg_decide u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .tick_i    (tick),
    .accept_i  (accept),
    .cnt_i     (cnt),
    .next_o    (next_cnt),
    .step_o    (step),
    .nmi_hit_o (nmi_hit),
    .rst_hit_o (rst_hit),
    .nmi_o     (nmi_o),
    .sys_rst_o (sys_rst_o)
  );

  wdg_count u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (load_val),
    .step_i     (step),
    .reload_i   (rst_hit),
    .next_i     (next_cnt),
    .cnt_o      (cnt)
  );

  assign rd_data_o = {{(WDG_REG_W-WDG_CNT_W){1'b0}}, cnt};

  // R6: the interrupt pulse coincides with a zero count
  p_nmi_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> rd_data_o == 16'h0000);
  // R7: the reset pulse coincides with the reloaded count
  p_rst_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> rd_data_o == 16'h00FF);
  // R3: a filtered write with no tick leaves the count alone
  p_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[15:9] != 7'd0 && !tick) |=> $stable(rd_data_o));
  // R9: a write beats a coincident tick
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tick) |=> rd_data_o == {7'd0, 1'b0, $past(wr_data_i[7:0])});
endmodule

// File: tb/sim_wdog_grace_timer.sv
module sim_wdog_grace_timer;
  localparam int P = 4;
  localparam int NV = 10;

  typedef struct packed {
    logic [15:0] data;
    logic        mode;
    logic [7:0]  ticks;
    logic [8:0]  cnt;
    logic        nmi;
    logic        rst;
  } vec_t;

  // write data, mode, ticks to wait, expected count / nmi / reset
  localparam vec_t VEC [NV] = '{
    '{16'h0005, 1'b0, 8'd2,  9'h003, 1'b0, 1'b0},  // R4
    '{16'h0002, 1'b0, 8'd2,  9'h000, 1'b1, 1'b0},  // R6
    '{16'h0001, 1'b0, 8'd3,  9'h1FE, 1'b0, 1'b0},  // R5
    '{16'h0010, 1'b0, 8'd32, 9'h0FF, 1'b0, 1'b1},  // R7
    '{16'h0003, 1'b1, 8'd3,  9'h0FF, 1'b0, 1'b1},  // R8
    '{16'h0003, 1'b1, 8'd2,  9'h001, 1'b0, 1'b0},  // R8
    '{16'h0000, 1'b1, 8'd1,  9'h0FF, 1'b0, 1'b1},  // R8
    '{16'h01AB, 1'b0, 8'd0,  9'h0AB, 1'b0, 1'b0},  // R2
    '{16'h00FF, 1'b0, 8'd5,  9'h0FA, 1'b0, 1'b0},  // R4
    '{16'h0000, 1'b0, 8'd0,  9'h000, 1'b0, 1'b0}   // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;
  logic        nmi;
  logic        sys_rst;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_grace_timer #(.TICK_CYCLES(P)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .nmi_o     (nmi),
    .sys_rst_o (sys_rst)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [8:0] c, input logic n, input logic r);
    check(req, rd_data, {7'd0, c});
    check(req, {15'd0, nmi}, {15'd0, n});
    check(req, {15'd0, sys_rst}, {15'd0, r});
  endtask

  // drive on the falling edge, return at the falling edge after the load
  task automatic write_reg(input logic [15:0] d, input logic m);
    mode    = m;
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 16'h0000;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    check_out("R1", 9'h0FF, 1'b0, 1'b0);
    rst_n = 1'b1;
    wait_cyc(1);
    check_out("R1", 9'h0FF, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      write_reg(VEC[i].data, VEC[i].mode);
      wait_cyc(int'(VEC[i].ticks) * P);
      check_out($sformatf("vector %0d", i), VEC[i].cnt, VEC[i].nmi, VEC[i].rst);
    end

    // R4: first decrement exactly P edges after the load
    write_reg(16'h0040, 1'b0);
    wait_cyc(P - 1);
    check("R4 early", rd_data, 16'h0040);
    wait_cyc(1);
    check("R4 step", rd_data, 16'h003F);

    // R3: filtered writes leave the count unchanged
    write_reg(16'h0050, 1'b0);
    write_reg(16'h0250, 1'b0);
    check("R3 guard bit 9", rd_data, 16'h0050);
    write_reg(16'h8011, 1'b0);
    check("R3 guard bit 15", rd_data, 16'h0050);

    // R9: accepted write in the tick cycle
    write_reg(16'h0020, 1'b0);
    wait_cyc(P - 1);
    write_reg(16'h0030, 1'b0);
    check("R9 collision", rd_data, 16'h0030);

    // R6: interrupt lasts one clock
    write_reg(16'h0001, 1'b0);
    wait_cyc(P);
    check_out("R6 pulse", 9'h000, 1'b1, 1'b0);
    wait_cyc(1);
    check_out("R6 pulse end", 9'h000, 1'b0, 1'b0);

    // R7 and R10: grace window end, then counting resumes
    write_reg(16'h0000, 1'b0);
    wait_cyc(16 * P);
    check_out("R7 grace end", 9'h0FF, 1'b0, 1'b1);
    wait_cyc(1);
    check_out("R7 pulse end", 9'h0FF, 1'b0, 1'b0);
    wait_cyc(P - 1);
    check_out("R10 resume", 9'h0FE, 1'b0, 1'b0);

    // R5: upper read bits stay zero while negative
    write_reg(16'h0000, 1'b0);
    wait_cyc(P);
    check("R5 wrap", rd_data, 16'h01FF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule